// File: doc/BRIEF.md
# Control Register Access and Permission Unit

This block sits between an instruction decoder and a small bank of control and status registers. Each request carries a 12-bit register number, the privilege level of the requester, a new value, a write mask and a debug-access flag. One cycle later the unit returns the register's previous value and a flag that marks the access as illegal. Legality comes from the register number itself, and from a per-register availability test. Bits [9:8] of the number give the lowest privilege allowed to touch the register. A value of 3 in bits [11:10] marks the register read-only.

A single masked merge path serves every access style. A plain read, a full write, a bit-set and a bit-clear differ only in the new value and the mask that the decoder supplies. The storage behind the unit is a stub holding these registers: floating-point flags, rounding mode, a combined floating-point control view, a user scratch, a read-only user info word, a supervisor scratch, a machine status word, a machine scratch and a read-only hart number.

A two-state controller handles the requests. In `ST_IDLE` no response is pending. In `ST_RESP` a response is on the outputs. The transition IDLE→RESP happens on any request. RESP→RESP happens on a back-to-back request. RESP→IDLE happens when no request arrives.

Top module: `csr_access_unit`

Register map:

| Number | Name | Access | Contents |
|---|---|---|---|
| 0x001 | fp flags | user RW, FP | 5 bits |
| 0x002 | fp rounding | user RW, FP | 3 bits |
| 0x003 | fp control | user RW, FP | rounding in [7:5], flags in [4:0] |
| 0x040 | user scratch | user RW | full width |
| 0xC10 | info | user RO | INFO_VALUE |
| 0x140 | supervisor scratch | supervisor RW | full width; present only when HAS_SMODE=1 |
| 0x300 | machine status | machine RW | see R9 |
| 0x340 | machine scratch | machine RW | full width |
| 0xF14 | hart number | machine RO | HART_ID |

## Requirements
- R1: Only the register numbers in the map are implemented. Any other number gives illegal=1, read data 0, and no change to any stored value.
- R2: Privilege is encoded as 0=user, 1=supervisor, 3=machine. An access whose privilege is below bits [9:8] of the register number is illegal and has no side effect.
- R3: When bits [11:10] of the number equal 3, any access with a nonzero write mask is illegal and changes nothing. A read with mask 0 is legal at sufficient privilege.
- R4: On a legal access with a nonzero mask, the stored value becomes (old AND NOT mask) OR (new AND mask). A mask of 0 writes nothing.
- R5: A legal access returns the register value as it was before the write.
- R6: The four access styles are encoded as follows. Read uses new=0, mask=0. Write uses new=operand, mask=all ones. Set uses new=all ones, mask=operand. Clear uses new=0, mask=operand. All four give the results of R4 and R5.
- R7: The three floating-point registers (0x001 to 0x003) are illegal while the status FS field (bits [14:13]) is 0, unless dbg_access=1.
- R8: A legal write with a nonzero mask to a floating-point register sets FS to 3.
- R9: Only status bits 1, 3, 5, 7, [12:11] and [14:13] are writable; all other bits read as 0. The most significant bit reads 1 exactly when FS is 3.
- R10: rsp_valid is 1 in the cycle after each cycle with req_valid=1 and is 0 otherwise. When rsp_illegal is 1, rsp_rdata is 0.
- R11: The fp control register aliases the other two: it reads as {rounding, flags}, and writing it updates both.
- R12: After reset all stored values are 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | request strobe |
| req_addr | input | 12 | register number |
| req_priv | input | 2 | requester privilege |
| req_wdata | input | XLEN | new value |
| req_wmask | input | XLEN | write mask |
| dbg_access | input | 1 | debugger access, overrides the FS gate |
| rsp_valid | output | 1 | response strobe |
| rsp_rdata | output | XLEN | value before the access, 0 if illegal |
| rsp_illegal | output | 1 | access rejected |

## Verification
The bench builds the unit with XLEN=32, HAS_SMODE=1, HART_ID=3 and INFO_VALUE=0x5A170001. At these values the 32-bit status summary bit (bit 31) and the supervisor scratch register are within reach. Sweeping user, supervisor and machine privilege over every register and all four access styles covers each privilege boundary and the read-only rule. Sweeping first with FS off and then with FS on exercises the floating-point gate in both states.

// File: rtl/csr_pkg.sv
package csr_pkg;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_FPFLAG,
        REG_FPRND,
        REG_FPCTL,
        REG_USCR,
        REG_INFO,
        REG_SSCR,
        REG_STAT,
        REG_MSCR,
        REG_HART
    } reg_id_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rsp_state_e;

    localparam logic [11:0] NUM_FPFLAG = 12'h001;
    localparam logic [11:0] NUM_FPRND  = 12'h002;
    localparam logic [11:0] NUM_FPCTL  = 12'h003;
    localparam logic [11:0] NUM_USCR   = 12'h040;
    localparam logic [11:0] NUM_INFO   = 12'hC10;
    localparam logic [11:0] NUM_SSCR   = 12'h140;
    localparam logic [11:0] NUM_STAT   = 12'h300;
    localparam logic [11:0] NUM_MSCR   = 12'h340;
    localparam logic [11:0] NUM_HART   = 12'hF14;

    localparam int FPFLAG_W = 5;
    localparam int FPRND_W  = 3;
    localparam int FS_LO    = 13;
    localparam int FS_HI    = 14;
    localparam logic [31:0] STAT_WMASK = 32'h0000_78AA;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic [11:0] addr,
    input  logic [1:0]  priv,
    input  logic        wr_req,
    input  logic        fs_on,
    input  logic        dbg,
    output reg_id_e     id,
    output logic        is_fp,
    output logic        illegal
);

    logic priv_low;
    logic ro_hit;
    logic fp_off;

    always_comb begin
        case (addr)
            NUM_FPFLAG: id = REG_FPFLAG;
            NUM_FPRND:  id = REG_FPRND;
            NUM_FPCTL:  id = REG_FPCTL;
            NUM_USCR:   id = REG_USCR;
            NUM_INFO:   id = REG_INFO;
            NUM_SSCR:   id = HAS_SMODE ? REG_SSCR : REG_NONE;
            NUM_STAT:   id = REG_STAT;
            NUM_MSCR:   id = REG_MSCR;
            NUM_HART:   id = REG_HART;
            default:    id = REG_NONE;
        endcase
    end

    always_comb begin
        is_fp    = (id == REG_FPFLAG) || (id == REG_FPRND) || (id == REG_FPCTL);
        priv_low = priv < addr[9:8];
        ro_hit   = (addr[11:10] == 2'b11) && wr_req;
        fp_off   = is_fp && !fs_on && !dbg;
        illegal  = (id == REG_NONE) || priv_low || ro_hit || fp_off;
    end

endmodule

// File: rtl/csr_merge.sv
module csr_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] mask,
    output logic [W-1:0] merged,
    output logic         any_bit
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign merged[b] = mask[b] ? new_val[b] : old_val[b];
    end

    assign any_bit = |mask;

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
    import csr_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter int unsigned      HART_ID    = 3,
    parameter logic [XLEN-1:0]  INFO_VALUE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  reg_id_e         rd_id,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_data,
    output logic            fs_on
);

    localparam logic [XLEN-1:0] STAT_MASK_X = XLEN'(STAT_WMASK);

    logic [FPFLAG_W-1:0] fpflag_q;
    logic [FPRND_W-1:0]  fprnd_q;
    logic [XLEN-1:0]     uscr_q;
    logic [XLEN-1:0]     sscr_q;
    logic [XLEN-1:0]     stat_q;
    logic [XLEN-1:0]     mscr_q;
    logic                fs_dirty;
    logic                fp_hit;

    always_comb begin
        fs_on    = stat_q[FS_HI:FS_LO] != 2'b00;
        fs_dirty = stat_q[FS_HI:FS_LO] == 2'b11;
        fp_hit   = (rd_id == REG_FPFLAG) || (rd_id == REG_FPRND) || (rd_id == REG_FPCTL);
    end

    always_comb begin
        case (rd_id)
            REG_FPFLAG: rd_data = XLEN'(fpflag_q);
            REG_FPRND:  rd_data = XLEN'(fprnd_q);
            REG_FPCTL:  rd_data = XLEN'({fprnd_q, fpflag_q});
            REG_USCR:   rd_data = uscr_q;
            REG_INFO:   rd_data = INFO_VALUE;
            REG_SSCR:   rd_data = sscr_q;
            REG_STAT:   rd_data = stat_q | {fs_dirty, {(XLEN-1){1'b0}}};
            REG_MSCR:   rd_data = mscr_q;
            REG_HART:   rd_data = XLEN'(HART_ID);
            default:    rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fpflag_q <= '0;
            fprnd_q  <= '0;
            uscr_q   <= '0;
            sscr_q   <= '0;
            stat_q   <= '0;
            mscr_q   <= '0;
        end else if (wr_en) begin
            case (rd_id)
                REG_FPFLAG: fpflag_q <= wr_data[FPFLAG_W-1:0];
                REG_FPRND:  fprnd_q  <= wr_data[FPRND_W-1:0];
                REG_FPCTL: begin
                    fpflag_q <= wr_data[FPFLAG_W-1:0];
                    fprnd_q  <= wr_data[FPFLAG_W+FPRND_W-1:FPFLAG_W];
                end
                REG_USCR:   uscr_q <= wr_data;
                REG_SSCR:   sscr_q <= wr_data;
                REG_STAT:   stat_q <= wr_data & STAT_MASK_X;
                REG_MSCR:   mscr_q <= wr_data;
                default: ;
            endcase
            if (fp_hit) begin
                stat_q[FS_HI:FS_LO] <= 2'b11;
            end
        end
    end

    // R8: any accepted floating-point write leaves FS dirty
    p_fs_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fp_hit) |=> (stat_q[FS_HI:FS_LO] == 2'b11));

    // R4: with no write enable, stored state does not move
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(stat_q) && $stable(mscr_q) && $stable(uscr_q)
                    && $stable(sscr_q) && $stable(fpflag_q) && $stable(fprnd_q)));

    // R9: non-writable status bits stay clear
    p_stat_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~STAT_MASK_X) == '0);

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter bit              HAS_SMODE  = 1'b1,
    parameter int unsigned     HART_ID    = 3,
    parameter logic [XLEN-1:0] INFO_VALUE = XLEN'(32'h5A17_0001)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [11:0]     req_addr,
    input  logic [1:0]      req_priv,
    input  logic [XLEN-1:0] req_wdata,
    input  logic [XLEN-1:0] req_wmask,
    input  logic            dbg_access,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_rdata,
    output logic            rsp_illegal
);

    rsp_state_e      state_q;
    rsp_state_e      state_d;
    reg_id_e         reg_id;
    logic            is_fp;
    logic            illegal;
    logic            fs_on;
    logic            wr_req;
    logic            wr_en;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] rdata_q;
    logic            illegal_q;

    csr_merge #(.W(XLEN)) u_merge (
        .old_val (old_val),
        .new_val (req_wdata),
        .mask    (req_wmask),
        .merged  (merged),
        .any_bit (wr_req)
    );

    csr_decode #(.HAS_SMODE(HAS_SMODE)) u_decode (
        .addr    (req_addr),
        .priv    (req_priv),
        .wr_req  (wr_req),
        .fs_on   (fs_on),
        .dbg     (dbg_access),
        .id      (reg_id),
        .is_fp   (is_fp),
        .illegal (illegal)
    );

    assign wr_en = req_valid && !illegal && wr_req;

    csr_regfile #(
        .XLEN       (XLEN),
        .HART_ID    (HART_ID),
        .INFO_VALUE (INFO_VALUE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_id   (reg_id),
        .wr_en   (wr_en),
        .wr_data (merged),
        .rd_data (old_val),
        .fs_on   (fs_on)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            illegal_q <= 1'b0;
        end else if (req_valid) begin
            rdata_q   <= illegal ? '0 : old_val;
            illegal_q <= illegal;
        end
    end

    assign rsp_valid   = (state_q == ST_RESP);
    assign rsp_rdata   = rdata_q;
    assign rsp_illegal = illegal_q;

    p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (rsp_rdata == '0));

    p_priv_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_priv < req_addr[9:8])) |=> rsp_illegal);

    p_ro_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[11:10] == 2'b11) && (req_wmask != '0)) |=> rsp_illegal);

    p_fp_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_fp && !fs_on && !dbg_access) |=> rsp_illegal);

endmodule

// File: tb/csr_access_unit_bench.sv
module csr_access_unit_bench;

    typedef struct {
        logic [31:0] rdata;
        logic        ill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_priv = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_wmask = '0;
    logic        dbg_access = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_illegal;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    // reference state
    logic [4:0]  m_ff = '0;
    logic [2:0]  m_rm = '0;
    logic [31:0] m_us = '0, m_ss = '0, m_st = '0, m_ms = '0;

    always #5 clk = ~clk;

    csr_access_unit u_csr_access_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_priv(req_priv), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .dbg_access(dbg_access), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_illegal(rsp_illegal)
    );

    function automatic bit m_impl(input logic [11:0] a);
        return a inside {12'h001, 12'h002, 12'h003, 12'h040, 12'hC10,
                         12'h140, 12'h300, 12'h340, 12'hF14};
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h001: return {27'd0, m_ff};
            12'h002: return {29'd0, m_rm};
            12'h003: return {24'd0, m_rm, m_ff};
            12'h040: return m_us;
            12'hC10: return 32'h5A17_0001;
            12'h140: return m_ss;
            12'h300: return m_st | {(m_st[14:13] == 2'b11), 31'd0};
            12'h340: return m_ms;
            12'hF14: return 32'd3;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // driver: compute expected from the requirements, push, drive one cycle
    task automatic access(input logic [11:0] a, input logic [1:0] p,
                          input logic [31:0] nv, input logic [31:0] mk,
                          input logic dbg, input string tag);
        exp_t e;
        logic [31:0] old, mrg;
        bit fp;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_priv = p;
        req_wdata = nv; req_wmask = mk; dbg_access = dbg;
        fp = (a == 12'h001) || (a == 12'h002) || (a == 12'h003);
        e.tag = tag;
        e.ill = !m_impl(a) || (p < a[9:8]) || ((a[11:10] == 2'b11) && (mk != 0))
                || (fp && (m_st[14:13] == 2'b00) && !dbg);
        old = m_read(a);
        e.rdata = e.ill ? 32'd0 : old;
        if (!e.ill && mk != 0) begin
            mrg = (old & ~mk) | (nv & mk);
            case (a)
                12'h001: m_ff = mrg[4:0];
                12'h002: m_rm = mrg[2:0];
                12'h003: begin m_ff = mrg[4:0]; m_rm = mrg[7:5]; end
                12'h040: m_us = mrg;
                12'h140: m_ss = mrg;
                12'h300: m_st = mrg & 32'h0000_78AA;
                12'h340: m_ms = mrg;
                default: ;
            endcase
            if (fp) m_st[14:13] = 2'b11;
        end
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_wmask = '0; req_wdata = '0; dbg_access = 1'b0;
    endtask

    // R6: the four access styles
    task automatic styles(input logic [11:0] a, input logic [1:0] p,
                          input logic [31:0] op, input string tag);
        access(a, p, 32'd0, 32'd0, 1'b0, {tag, " R6 read"});
        access(a, p, op, 32'hFFFF_FFFF, 1'b0, {tag, " R6 write"});
        access(a, p, 32'hFFFF_FFFF, op ^ 32'h0F0F_0F0F, 1'b0, {tag, " R6 set"});
        access(a, p, 32'd0, op, 1'b0, {tag, " R6 clear"});
        access(a, p, 32'd0, 32'd0, 1'b0, {tag, " R5 readback"});
    endtask

    // monitor: pop and compare
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R10 response without request", rsp_rdata, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_illegal == e.ill, {e.tag, " illegal flag"},
                      {31'd0, rsp_illegal}, {31'd0, e.ill});
                check(rsp_rdata == e.rdata, {e.tag, " data"}, rsp_rdata, e.rdata);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    logic [11:0] regs [0:9];
    initial begin
        regs = '{12'h001, 12'h002, 12'h003, 12'h040, 12'hC10,
                 12'h140, 12'h300, 12'h340, 12'hF14, 12'h7C0};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        // R12: every readable register starts at 0 (FP via debug read)
        access(12'h340, 2'd3, 0, 0, 1'b0, "R12 reset mscratch");
        access(12'h300, 2'd3, 0, 0, 1'b0, "R12 reset status");
        access(12'h040, 2'd0, 0, 0, 1'b0, "R12 reset uscratch");
        access(12'h003, 2'd0, 0, 0, 1'b1, "R12 R7 reset fp ctl debug");
        idle();
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 idle after gap", {31'd0, rsp_valid}, 32'd0);

        // R1 / R2 / R3 / R7 sweep with FS off
        foreach (regs[i]) begin
            styles(regs[i], 2'd0, 32'hA5C3_1E78, "R2 R7 user FS off");
            styles(regs[i], 2'd1, 32'h3C96_E101, "R2 supervisor FS off");
        end
        access(12'h7C0, 2'd3, 32'h1, 32'hFFFF_FFFF, 1'b0, "R1 R10 unimplemented write");
        access(12'hF14, 2'd3, 32'h0, 32'h1, 1'b0, "R3 read-only clear");
        access(12'hF14, 2'd3, 32'h0, 32'h0, 1'b0, "R3 read-only read");
        access(12'hC10, 2'd0, 32'h0, 32'h0, 1'b0, "R3 user info read");
        // R9 status mask and summary bit
        access(12'h300, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 status all ones");
        access(12'h300, 2'd3, 32'h0, 32'h0000_4000, 1'b0, "R9 status clear FS hi");
        access(12'h300, 2'd3, 32'h0, 32'h0, 1'b0, "R9 summary bit off");
        // R7/R8: debug write with FS off sets FS dirty
        access(12'h300, 2'd3, 32'h0, 32'hFFFF_FFFF, 1'b0, "R9 status zero");
        access(12'h001, 2'd0, 32'h15, 32'hFFFF_FFFF, 1'b1, "R7 debug fp write");
        access(12'h300, 2'd3, 32'h0, 32'h0, 1'b0, "R8 FS dirty after fp write");
        // R11 alias
        access(12'h003, 2'd0, 32'hFF, 32'hFFFF_FFFF, 1'b0, "R11 fp ctl write");
        access(12'h001, 2'd0, 32'h0, 32'h0, 1'b0, "R11 flags view");
        access(12'h002, 2'd0, 32'h0, 32'h0, 1'b0, "R11 rounding view");
        access(12'h002, 2'd0, 32'h0, 32'h5, 1'b0, "R11 rounding clear");
        access(12'h003, 2'd0, 32'h0, 32'h0, 1'b0, "R11 fp ctl read");
        // R4: zero mask leaves data unchanged
        access(12'h340, 2'd3, 32'h1234_5678, 32'hFFFF_FFFF, 1'b0, "R4 preload");
        access(12'h340, 2'd3, 32'hFFFF_FFFF, 32'h0, 1'b0, "R4 zero mask");
        access(12'h340, 2'd3, 32'hCAFE_0000, 32'hFFFF_0000, 1'b0, "R4 partial mask");
        access(12'h340, 2'd3, 32'h0, 32'h0, 1'b0, "R5 old value");
        // sweep with FS dirty, all privileges
        foreach (regs[i]) begin
            styles(regs[i], 2'd0, 32'h0FF0_55AA, "R2 user FS on");
            styles(regs[i], 2'd1, 32'hF00F_AA55, "R2 supervisor FS on");
            styles(regs[i], 2'd3, 32'h8001_7FFE, "R4 machine FS on");
        end
        idle();
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R10 all responses seen", q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule